// File: doc/BRIEF.md
# RGB LED Register Target on a Two-Wire Serial Bus

This block is a write-only target on a two-wire serial bus (SCL clock, SDA data). A bus master addresses it by a fixed 7-bit device address. It then sends a register pointer followed by any number of data bytes. Each data byte lands in one of three colour channel registers, red, green or blue. Each register holds a switch bit and a 7-bit drive code. The codes are driven out as registered values for a downstream current DAC. Each channel also has a registered active flag, which is the AND of its switch bit, an external enable pin and an active-low standby pin.

Both bus lines are oversampled by a system clock that is at least ten times faster than SCL. The lines pass through synchronizers, and the block detects START, STOP and SCL edges from the synchronized copies. The block acknowledges a byte by requesting that SDA be pulled low; the pad logic performs the open-drain drive. The block has no streaming data path, so every pin is a plain level signal with no valid/ready handshake. The enable and standby pins are assumed synchronous to the system clock.

Top module: `rgb_led_i2c_target`

## Requirements
- R1: After reset, all three drive codes are 0, all active flags are 0 and the SDA pull request is 0.
- R2: A first byte of 0xEA (device address 1110101 followed by a write bit of 0) is acknowledged: the pull request is high while SCL is high in the 9th clock and is low again once that clock has fallen.
- R3: A first byte with a different address, or with the direction bit set (0xEB), is not acknowledged. No later byte is acknowledged or stored until the next START.
- R4: The second byte is the register pointer: 0 selects red, 1 selects green and 2 selects blue. In a data byte, bit 7 is the switch bit and bits 6:0 are the drive code. The codes are output as red on bits 6:0, green on 13:7 and blue on 20:14.
- R5: The pointer increments after each data byte, so one transfer can fill consecutive channels.
- R6: A pointer above 2 is still acknowledged, but its data byte is discarded and no code changes.
- R7: Active flag i (bit 0 red, bit 1 green, bit 2 blue) is high exactly when switch bit i is 1, the enable pin is high and the standby pin is high, with one clock of latency.
- R8: Writes are stored while the standby pin is low. Standby never clears the stored registers.
- R9: A repeated START in the middle of a transfer restarts address decoding; a pointer sent before it does not receive data.
- R10: STOP returns the target to idle with the pull request low. Bytes clocked afterwards without a START are neither acknowledged nor stored.
- R11: The target works both with SCL at 1/40 of the system clock and with SCL at 1/12 of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | High requests the pad to drive SDA low |
| led_en_i | input | 1 | External enable for all channels |
| stby_n_i | input | 1 | Low puts all channels in standby |
| ch_code_o | output | 21 | Three 7-bit drive codes, red in the lowest bits |
| ch_act_o | output | 3 | Per-channel active flags |

## Verification
The bench runs single-byte writes, three-byte bursts and writes that run past the last channel. Together these separate correct pointer selection from off-by-one increments and from writes that should have been discarded. Bad addresses and the read bit are tested to show that the block rejects them and stays silent until the next START. Repeated START and bytes clocked after a STOP show that framing resets the decoder. The enable and standby pins are toggled around writes to separate output gating from register storage. One write is repeated at a much faster SCL to exercise the synchronizer margin.

// File: rtl/led_i2c_pkg.sv
package led_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 7;
  localparam int CNT_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_DATA,
    ST_SKIP
  } rx_state_t;

  typedef struct packed {
    logic              sw;
    logic [CODE_W-1:0] code;
  } chan_reg_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] synced;
  logic [NLINES-1:0] prev;

  assign raw = {sda_i, scl_i};

  for (genvar l = 0; l < NLINES; l++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain   <= '1;
        prev[l] <= 1'b1;
      end else begin
        chain   <= {chain[STAGES-2:0], raw[l]};
        prev[l] <= chain[STAGES-1];
      end
    end
    assign synced[l] = chain[STAGES-1];
  end

  logic scl_s, scl_d, sda_d;
  assign scl_s = synced[0];
  assign sda_s = synced[1];
  assign scl_d = prev[0];
  assign sda_d = prev[1];

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_wr_engine.sv
module i2c_wr_engine
  import led_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1110101,
  parameter int         REG_AW   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_bit,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              sda_pull,
  output logic              wr_stb,
  output logic [REG_AW-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              ignoring
);
  localparam logic [BYTE_W-1:0] ADDR_WR = {DEV_ADDR, 1'b0};
  localparam logic [CNT_W-1:0]  FULL    = CNT_W'(BYTE_W);
  localparam logic [REG_AW-1:0] PTR_MAX = '1;

  rx_state_t         st;
  logic [BYTE_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              ack_ph;
  logic [REG_AW-1:0] ptr;
  logic              receiving;

  assign receiving = (st == ST_ADDR) || (st == ST_PTR) || (st == ST_DATA);
  assign ignoring  = (st == ST_SKIP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      sh       <= '0;
      cnt      <= '0;
      ack_ph   <= 1'b0;
      ptr      <= '0;
      sda_pull <= 1'b0;
      wr_stb   <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (stop_det) begin
        st       <= ST_IDLE;
        sda_pull <= 1'b0;
        ack_ph   <= 1'b0;
        cnt      <= '0;
      end else if (start_det) begin
        st       <= ST_ADDR;
        sda_pull <= 1'b0;
        ack_ph   <= 1'b0;
        cnt      <= '0;
      end else if (scl_rise && !ack_ph && receiving) begin
        sh  <= {sh[BYTE_W-2:0], sda_bit};
        cnt <= cnt + 1'b1;
      end else if (scl_fall) begin
        if (ack_ph) begin
          sda_pull <= 1'b0;
          ack_ph   <= 1'b0;
          cnt      <= '0;
        end else if (cnt == FULL) begin
          unique case (st)
            ST_ADDR: begin
              if (sh == ADDR_WR) begin
                sda_pull <= 1'b1;
                ack_ph   <= 1'b1;
                st       <= ST_PTR;
              end else begin
                st <= ST_SKIP;
              end
            end
            ST_PTR: begin
              ptr      <= REG_AW'(sh);
              sda_pull <= 1'b1;
              ack_ph   <= 1'b1;
              st       <= ST_DATA;
            end
            ST_DATA: begin
              wr_stb   <= 1'b1;
              wr_addr  <= ptr;
              wr_data  <= sh;
              if (ptr != PTR_MAX) ptr <= ptr + 1'b1;
              sda_pull <= 1'b1;
              ack_ph   <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/led_chan_bank.sv
module led_chan_bank
  import led_i2c_pkg::*;
#(
  parameter int N_CH   = 3,
  parameter int REG_AW = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_stb,
  input  logic [REG_AW-1:0]      wr_addr,
  input  logic [BYTE_W-1:0]      wr_data,
  input  logic                   led_en,
  input  logic                   stby_n,
  output logic [N_CH*CODE_W-1:0] code_o,
  output logic [N_CH-1:0]        act_o
);
  chan_reg_t wdat;
  logic      gate;

  assign wdat = chan_reg_t'(wr_data);
  assign gate = led_en & stby_n;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    chan_reg_t ch;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ch       <= '0;
        act_o[i] <= 1'b0;
      end else begin
        if (wr_stb && wr_addr == REG_AW'(i)) ch <= wdat;
        act_o[i] <= ch.sw & gate;
      end
    end
    assign code_o[i*CODE_W +: CODE_W] = ch.code;
  end
endmodule

// File: rtl/rgb_led_i2c_target.sv
module rgb_led_i2c_target
  import led_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1110101,
  parameter int         N_CH        = 3,
  parameter int         REG_AW      = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_pull_o,
  input  logic                   led_en_i,
  input  logic                   stby_n_i,
  output logic [N_CH*CODE_W-1:0] ch_code_o,
  output logic [N_CH-1:0]        ch_act_o
);
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_stb, ignoring;
  logic [REG_AW-1:0] wr_addr;
  logic [BYTE_W-1:0] wr_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_wr_engine #(.DEV_ADDR(DEV_ADDR), .REG_AW(REG_AW)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_bit(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .sda_pull(sda_pull_o), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .ignoring(ignoring)
  );

  led_chan_bank #(.N_CH(N_CH), .REG_AW(REG_AW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .led_en(led_en_i), .stby_n(stby_n_i),
    .code_o(ch_code_o), .act_o(ch_act_o)
  );
endmodule

// File: rtl/led_i2c_checker.sv
module led_i2c_checker #(
  parameter int N_CH   = 3,
  parameter int CODE_W = 7,
  parameter int REG_AW = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   scl_i,
  input logic                   led_en_i,
  input logic                   stby_n_i,
  input logic                   sda_pull_o,
  input logic [N_CH*CODE_W-1:0] ch_code_o,
  input logic [N_CH-1:0]        ch_act_o,
  input logic                   wr_stb,
  input logic [REG_AW-1:0]      wr_addr,
  input logic                   stop_det,
  input logic                   ignoring
);
  // R2: the acknowledge pull only changes while SCL is low
  a_r2_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_i);

  // R3: a rejected transfer never pulls SDA
  a_r3_silent_when_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    ignoring |-> !sda_pull_o);

  // R6: a write past the last channel leaves every code unchanged
  a_r6_high_ptr_discarded: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr >= REG_AW'(N_CH)) |=> $stable(ch_code_o));

  // R4: codes only move after a write strobe
  a_r4_code_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ch_code_o) |-> $past(wr_stb));

  // R7: any active flag needs both enable and standby released one clock earlier
  a_r7_act_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_act_o != '0) |-> ($past(led_en_i) && $past(stby_n_i)));

  // R10: STOP releases SDA
  a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull_o);
endmodule

bind rgb_led_i2c_target led_i2c_checker #(
  .N_CH(N_CH), .CODE_W(led_i2c_pkg::CODE_W), .REG_AW(REG_AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .led_en_i(led_en_i),
  .stby_n_i(stby_n_i), .sda_pull_o(sda_pull_o), .ch_code_o(ch_code_o),
  .ch_act_o(ch_act_o), .wr_stb(wr_stb), .wr_addr(wr_addr),
  .stop_det(stop_det), .ignoring(ignoring)
);

// File: tb/sim_rgb_led_i2c_target.sv
`timescale 1ns/1ps
module sim_rgb_led_i2c_target;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_tb = 1'b1;
  logic        sda_tb = 1'b1;
  logic        sda_line;
  logic        sda_pull_o;
  logic        led_en_i = 1'b1;
  logic        stby_n_i = 1'b1;
  logic [20:0] ch_code_o;
  logic [2:0]  ch_act_o;

  int checks = 0;
  int fails  = 0;
  int q      = 10;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_line = sda_tb & ~sda_pull_o;

  rgb_led_i2c_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_tb), .sda_i(sda_line),
    .sda_pull_o(sda_pull_o), .led_en_i(led_en_i), .stby_n_i(stby_n_i),
    .ch_code_o(ch_code_o), .ch_act_o(ch_act_o)
  );

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int red();   return int'(ch_code_o[6:0]);   endfunction
  function automatic int green(); return int'(ch_code_o[13:7]);  endfunction
  function automatic int blue();  return int'(ch_code_o[20:14]); endfunction

  task automatic bus_start();
    sda_tb = 1'b1; wt(q);
    scl_tb = 1'b1; wt(q);
    sda_tb = 1'b0; wt(q);
    scl_tb = 1'b0; wt(q);
  endtask

  task automatic bus_stop();
    sda_tb = 1'b0; wt(q);
    scl_tb = 1'b1; wt(q);
    sda_tb = 1'b1; wt(4 * q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_tb = b[i]; wt(q);
      scl_tb = 1'b1; wt(2 * q);
      scl_tb = 1'b0; wt(q);
    end
    sda_tb = 1'b1; wt(q);
    scl_tb = 1'b1; wt(q);
    ack = sda_pull_o;
    wt(q);
    scl_tb = 1'b0; wt(q);
  endtask

  task automatic t_reset();
    chk("R1 codes", int'(ch_code_o), 0);
    chk("R1 act", int'(ch_act_o), 0);
    chk("R1 pull", int'(sda_pull_o), 0);
  endtask

  task automatic t_single();
    logic a;
    bus_start();
    send_byte(8'hEA, a); chk("R2 address ack", a, 1);
    chk("R2 released after 9th clock", int'(sda_pull_o), 0);
    send_byte(8'h00, a); chk("R4 pointer ack", a, 1);
    send_byte(8'h85, a); chk("R4 data ack", a, 1);
    bus_stop();
    chk("R4 red code", red(), 5);
    chk("R7 red active", int'(ch_act_o), 1);
  endtask

  task automatic t_burst();
    logic a;
    bus_start();
    send_byte(8'hEA, a);
    send_byte(8'h01, a);
    send_byte(8'hFF, a); chk("R5 green ack", a, 1);
    send_byte(8'h2A, a); chk("R5 blue ack", a, 1);
    bus_stop();
    chk("R5 green code", green(), 8'h7F);
    chk("R5 blue code", blue(), 8'h2A);
    chk("R7 act red+green", int'(ch_act_o), 3);
  endtask

  task automatic t_high_ptr();
    logic a;
    bus_start();
    send_byte(8'hEA, a);
    send_byte(8'h02, a);
    send_byte(8'h11, a);
    send_byte(8'h99, a); chk("R6 ack past blue", a, 1);
    bus_stop();
    chk("R6 blue written", blue(), 8'h11);
    chk("R6 red kept", red(), 5);
    chk("R6 green kept", green(), 8'h7F);
    bus_start();
    send_byte(8'hEA, a);
    send_byte(8'h07, a); chk("R6 pointer 7 ack", a, 1);
    send_byte(8'h55, a); chk("R6 data at 7 ack", a, 1);
    bus_stop();
    chk("R6 codes unchanged", int'(ch_code_o), int'({7'h11, 7'h7F, 7'h05}));
  endtask

  task automatic t_bad_addr();
    logic a;
    bus_start();
    send_byte(8'hE8, a); chk("R3 wrong address nack", a, 0);
    send_byte(8'h00, a); chk("R3 pointer nack", a, 0);
    send_byte(8'h7F, a); chk("R3 data nack", a, 0);
    bus_stop();
    chk("R3 red unchanged", red(), 5);
    bus_start();
    send_byte(8'hEB, a); chk("R3 read bit nack", a, 0);
    bus_stop();
  endtask

  task automatic t_pins();
    logic a;
    led_en_i = 1'b0; wt(2);
    chk("R7 enable low", int'(ch_act_o), 0);
    led_en_i = 1'b1; stby_n_i = 1'b0; wt(2);
    chk("R7 standby", int'(ch_act_o), 0);
    bus_start();
    send_byte(8'hEA, a);
    send_byte(8'h00, a);
    send_byte(8'hA2, a); chk("R8 ack in standby", a, 1);
    bus_stop();
    chk("R8 red stored in standby", red(), 8'h22);
    chk("R8 still inactive", int'(ch_act_o), 0);
    stby_n_i = 1'b1; wt(2);
    chk("R8 registers kept", int'(ch_act_o), 3);
  endtask

  task automatic t_restart();
    logic a;
    bus_start();
    send_byte(8'hEA, a);
    send_byte(8'h00, a);
    bus_start();
    send_byte(8'hEA, a); chk("R9 address after restart", a, 1);
    send_byte(8'h01, a);
    send_byte(8'h93, a);
    bus_stop();
    chk("R9 green", green(), 8'h13);
    chk("R9 red untouched", red(), 8'h22);
  endtask

  task automatic t_stop();
    logic a;
    bus_start();
    send_byte(8'hEA, a);
    send_byte(8'h00, a);
    bus_stop();
    chk("R10 pull after stop", int'(sda_pull_o), 0);
    send_byte(8'h81, a); chk("R10 no ack without start", a, 0);
    send_byte(8'h81, a);
    bus_stop();
    chk("R10 red unchanged", red(), 8'h22);
  endtask

  task automatic t_fast();
    logic a;
    q = 3;
    bus_start();
    send_byte(8'hEA, a); chk("R11 fast address ack", a, 1);
    send_byte(8'h02, a);
    send_byte(8'hC4, a); chk("R11 fast data ack", a, 1);
    bus_stop();
    chk("R11 fast blue", blue(), 8'h44);
    chk("R11 blue active", int'(ch_act_o), 7);
    q = 10;
  endtask

  initial begin
    wt(5);
    rst_n = 1'b1;
    wt(5);
    t_reset();
    t_single();
    t_burst();
    t_high_ptr();
    t_bad_addr();
    t_pins();
    t_restart();
    t_stop();
    t_fast();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule